// File: doc/BRIEF.md
# Sequential Integer Multiply-Divide Unit

This unit performs the eight integer multiply and divide operations of the RISC-V M extension on 32-bit operands, one bit per clock. It provides the low multiply, three high multiplies (signed by signed, signed by unsigned, unsigned by unsigned), signed and unsigned division, and signed and unsigned remainder. A caller presents two operands and an operation code with a one-cycle start strobe. Some cycles later a one-cycle done strobe marks a valid result on the result port.

Signed operations are reduced to magnitudes when the operands are captured. A single 64-bit working register then runs either radix-2 shift-and-add multiplication or restoring division for one step per operand bit. A final correction cycle restores the sign and picks the requested half. Division by zero and the most-negative-by-minus-one overflow give fixed architectural values and raise no exception.

Top module: `mdu_seq`

## Requirements
- R1: While idle (busy_o low) a start_i pulse captures a_i, b_i and op_i, and busy_o is high from the next cycle until the result is delivered. op_i encodes 0 low multiply, 1 signed high multiply, 2 signed-by-unsigned high multiply, 3 unsigned high multiply, 4 signed divide, 5 unsigned divide, 6 signed remainder, 7 unsigned remainder.
- R2: done_o is high for exactly one cycle, 33 clock edges after the edge that captured start_i (32 iteration cycles plus one correction cycle). result_o is valid in that cycle and holds its value until the next result.
- R3: Operation 0 returns bits 31:0 of the product, the same value for any operand signedness.
- R4: Operation 1 sign-extends both operands to 64 bits and returns product bits 63:32.
- R5: Operation 2 sign-extends a_i, zero-extends b_i and returns product bits 63:32.
- R6: Operation 3 zero-extends both operands and returns product bits 63:32.
- R7: Operations 4 and 5 return the quotient. The signed quotient is truncated toward zero.
- R8: Operations 6 and 7 return the remainder. The signed remainder has the sign of the dividend.
- R9: With b_i equal to zero, operations 4 and 5 return 0xFFFFFFFF.
- R10: With b_i equal to zero, operations 6 and 7 return a_i unchanged.
- R11: Signed division of 0x80000000 by 0xFFFFFFFF returns 0x80000000, and the signed remainder for the same operands is 0.
- R12: A start_i pulse while busy_o is high is ignored: the running operation completes with its original operands and no extra done_o pulse follows.
- R13: After reset busy_o and done_o are low and result_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| op_i | input | 3 | Operation code |
| a_i | input | 32 | First operand (multiplicand or dividend) |
| b_i | input | 32 | Second operand (multiplier or divisor) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result strobe |
| result_o | output | 32 | Result, held between operations |

## Verification
The bench targets the cases where sign handling goes wrong. These are negative operands in every high multiply, where a missing sign correction leaves the unsigned high half. A mixed multiply whose second operand has its top bit set exposes a design that sign-extends it. Signed division and remainder with every sign combination catch rounding away from zero or a remainder that takes the divisor's sign. Divisor zero checks that the quotient is not negated to 1 and that the remainder is not replaced by its magnitude. The overflow pair 0x80000000 / -1 must give 0x80000000 and 0. A start pulse during a run would restart or corrupt the operation, and an off-by-one iteration count moves the done strobe away from edge 33.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [2:0] {
    OP_MUL    = 3'd0,
    OP_MULH   = 3'd1,
    OP_MULHSU = 3'd2,
    OP_MULHU  = 3'd3,
    OP_DIV    = 3'd4,
    OP_DIVU   = 3'd5,
    OP_REM    = 3'd6,
    OP_REMU   = 3'd7
  } mdu_op_e;

  typedef struct packed {
    mdu_op_e op;
    logic    neg_p;   // product or quotient must be negated
    logic    neg_r;   // remainder must be negated
    logic    b_zero;
  } mdu_ctx_t;

  function automatic logic op_is_div(mdu_op_e op);
    return op[2];
  endfunction

  function automatic logic op_a_signed(mdu_op_e op);
    return (op == OP_MULH) || (op == OP_MULHSU) || (op == OP_DIV) || (op == OP_REM);
  endfunction

  function automatic logic op_b_signed(mdu_op_e op);
    return (op == OP_MULH) || (op == OP_DIV) || (op == OP_REM);
  endfunction

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl #(
  parameter int W = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic load_o,
  output logic step_o,
  output logic fix_o,
  output logic done_o
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX} st_e;

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign load_o = start_i && (st_q == ST_IDLE);
  assign step_o = (st_q == ST_RUN);
  assign fix_o  = (st_q == ST_FIX);
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fix_o;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_RUN;
          cnt_q <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) st_q <= ST_FIX;
        end
        ST_FIX:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_FIX_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_o |-> $past(step_o)); // R2
  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && start_i && cnt_q != LAST) |=> (step_o && cnt_q == $past(cnt_q) + 1'b1)); // R12
  AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> busy_o); // R1

endmodule

// File: rtl/mdu_prep.sv
module mdu_prep
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  mdu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output mdu_ctx_t     ctx_o,
  output logic [W-1:0] a_raw_o,
  output logic [W-1:0] b_raw_o
);
  logic     a_neg, b_neg;
  mdu_ctx_t ctx_d, ctx_q;
  logic [W-1:0] a_raw_q, b_raw_q;

  assign a_neg   = op_a_signed(op_i) && a_i[W-1];
  assign b_neg   = op_b_signed(op_i) && b_i[W-1];
  assign mag_a_o = a_neg ? (~a_i + 1'b1) : a_i;
  assign mag_b_o = b_neg ? (~b_i + 1'b1) : b_i;

  always_comb begin
    ctx_d.op     = op_i;
    ctx_d.neg_p  = a_neg ^ b_neg;
    ctx_d.neg_r  = a_neg;
    ctx_d.b_zero = (b_i == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_q   <= '0;
      a_raw_q <= '0;
      b_raw_q <= '0;
    end else if (load_i) begin
      ctx_q   <= ctx_d;
      a_raw_q <= a_i;
      b_raw_q <= b_i;
    end
  end

  assign ctx_o   = ctx_q;
  assign a_raw_o = a_raw_q;
  assign b_raw_o = b_raw_q;

  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_i) |-> (ctx_q.b_zero == (b_raw_q == '0))); // R9

endmodule

// File: rtl/mdu_iter.sv
module mdu_iter #(
  parameter int W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic           div_i,
  input  logic           load_div_i,
  input  logic [W-1:0]   mag_a_i,
  input  logic [W-1:0]   mag_b_i,
  output logic [2*W-1:0] acc_o
);
  logic [2*W-1:0] acc_q, acc_d;
  logic [W-1:0]   opd_q;
  logic [W-1:0]   hi, lo;
  logic [W:0]     mul_sum;
  logic [W:0]     div_t;
  logic [W+1:0]   div_diff;

  assign hi = acc_q[2*W-1:W];
  assign lo = acc_q[W-1:0];

  // multiply: add multiplicand to high half on LSB, shift right
  assign mul_sum  = {1'b0, hi} + (lo[0] ? {1'b0, opd_q} : '0);
  // divide: shift in next dividend bit, trial subtract
  assign div_t    = {hi, lo[W-1]};
  assign div_diff = {1'b0, div_t} - {2'b00, opd_q};

  always_comb begin
    if (div_i) begin
      if (!div_diff[W+1]) acc_d = {div_diff[W-1:0], lo[W-2:0], 1'b1};
      else                acc_d = {div_t[W-1:0], lo[W-2:0], 1'b0};
    end else begin
      acc_d = {mul_sum, lo[W-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      opd_q <= '0;
    end else if (load_i) begin
      acc_q <= {{W{1'b0}}, (load_div_i ? mag_a_i : mag_b_i)};
      opd_q <= load_div_i ? mag_b_i : mag_a_i;
    end else if (step_i) begin
      acc_q <= acc_d;
    end
  end

  assign acc_o = acc_q;

  AST_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && div_i && opd_q != '0) |=> (acc_q[2*W-1:W] < opd_q)); // R8

endmodule

// File: rtl/mdu_finish.sv
module mdu_finish
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           fix_i,
  input  mdu_ctx_t       ctx_i,
  input  logic [2*W-1:0] acc_i,
  input  logic [W-1:0]   a_raw_i,
  input  logic [W-1:0]   b_raw_i,
  output logic [W-1:0]   result_o
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic [2*W-1:0] prod;
  logic [W-1:0]   quo, rem, res_d, res_q;

  assign prod = ctx_i.neg_p ? (~acc_i + 1'b1) : acc_i;
  assign quo  = (ctx_i.neg_p && !ctx_i.b_zero) ? (~acc_i[W-1:0] + 1'b1) : acc_i[W-1:0];
  assign rem  = ctx_i.neg_r ? (~acc_i[2*W-1:W] + 1'b1) : acc_i[2*W-1:W];

  always_comb begin
    unique case (ctx_i.op)
      OP_MUL:                         res_d = prod[W-1:0];
      OP_MULH, OP_MULHSU, OP_MULHU:   res_d = prod[2*W-1:W];
      OP_DIV, OP_DIVU:                res_d = quo;
      default:                        res_d = rem;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    res_q <= '0;
    else if (fix_i) res_q <= res_d;
  end

  assign result_o = res_q;

  AST_DIV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fix_i && (ctx_i.op == OP_DIV || ctx_i.op == OP_DIVU) && b_raw_i == '0)
      |=> (result_o == '1)); // R9
  AST_REM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fix_i && (ctx_i.op == OP_REM || ctx_i.op == OP_REMU) && b_raw_i == '0)
      |=> (result_o == $past(a_raw_i))); // R10
  AST_DIV_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fix_i && ctx_i.op == OP_DIV && a_raw_i == MIN_NEG && b_raw_i == '1)
      |=> (result_o == MIN_NEG)); // R11
  AST_REM_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fix_i && ctx_i.op == OP_REM && a_raw_i == MIN_NEG && b_raw_i == '1)
      |=> (result_o == '0)); // R11
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(fix_i) |-> $stable(result_o)); // R2

endmodule

// File: rtl/mdu_seq.sv
module mdu_seq
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  logic           load, step, fix;
  logic [W-1:0]   mag_a, mag_b, a_raw, b_raw;
  logic [2*W-1:0] acc;
  mdu_ctx_t       ctx;
  mdu_op_e        op_in;

  assign op_in = mdu_op_e'(op_i);

  mdu_ctrl #(.W(W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .busy_o (busy_o),
    .load_o (load),
    .step_o (step),
    .fix_o  (fix),
    .done_o (done_o)
  );

  mdu_prep #(.W(W)) u_prep (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .op_i   (op_in),
    .a_i    (a_i),
    .b_i    (b_i),
    .mag_a_o(mag_a),
    .mag_b_o(mag_b),
    .ctx_o  (ctx),
    .a_raw_o(a_raw),
    .b_raw_o(b_raw)
  );

  mdu_iter #(.W(W)) u_iter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .step_i    (step),
    .div_i     (op_is_div(ctx.op)),
    .load_div_i(op_is_div(op_in)),
    .mag_a_i   (mag_a),
    .mag_b_i   (mag_b),
    .acc_o     (acc)
  );

  mdu_finish #(.W(W)) u_finish (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fix_i   (fix),
    .ctx_i   (ctx),
    .acc_i   (acc),
    .a_raw_i (a_raw),
    .b_raw_i (b_raw),
    .result_o(result_o)
  );

  AST_DONE_IMPLIES_BUSY_PRIOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o)); // R1

endmodule

// File: tb/tb_mdu_seq.sv
module tb_mdu_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic        busy, done;
  logic [31:0] result;

  always #5ns clk = ~clk;

  mdu_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .a_i(a), .b_i(b), .busy_o(busy), .done_o(done), .result_o(result)
  );

  typedef struct {
    logic [31:0] val;
    int          cyc;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_vec = 0;
  int          n_bad = 0;
  int          cyc = 0;
  logic [31:0] seed = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_model(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    longint      sx, sy, sp;
    logic [63:0] up;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    case (o)
      3'd0: begin up = {32'h0, x} * {32'h0, y}; return up[31:0]; end
      3'd1: begin sp = sx * sy; up = sp; return up[63:32]; end
      3'd2: begin sp = sx * longint'({32'h0, y}); up = sp; return up[63:32]; end
      3'd3: begin up = {32'h0, x} * {32'h0, y}; return up[63:32]; end
      3'd4: begin
        if (y == 0) return 32'hFFFF_FFFF;
        if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return 32'h8000_0000;
        sp = sx / sy; up = sp; return up[31:0];
      end
      3'd5: return (y == 0) ? 32'hFFFF_FFFF : x / y;
      3'd6: begin
        if (y == 0) return x;
        if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return 32'h0;
        sp = sx % sy; up = sp; return up[31:0];
      end
      default: return (y == 0) ? x : x % y;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    if (o[2] && y == 0) return o[1] ? "R10" : "R9";
    if (o == 3'd4 || o == 3'd6)
      if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return "R11";
    case (o)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4, 3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  // monitor: compares each done pulse with the scoreboard head, value and cycle
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R12 spurious done", result, 32'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(result == e.val, e.tag, result, e.val);
        check(cyc == e.cyc, "R2 latency", 32'(cyc), 32'(e.cyc));
      end
    end
  end

  task automatic wait_drain();
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    exp_t e;
    e.val = ref_model(o, x, y);
    e.cyc = cyc + 34;
    e.tag = tag_of(o, x, y);
    sb_q.push_back(e);
    op = o; a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R1 busy after start", 32'(busy), 32'h1);
  endtask

  task automatic run(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    issue(o, x, y);
    wait_drain();
  endtask

  function automatic logic [31:0] next_rand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed ^ {seed[15:0], seed[31:16]};
  endfunction

  initial begin
    #1_500_000ns;
    check(1'b0, "watchdog", 32'(cyc), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R13 busy", 32'(busy), 32'h0);
    check(done == 1'b0, "R13 done", 32'(done), 32'h0);
    check(result == 32'h0, "R13 result", result, 32'h0);

    // R3..R6: sign mixes on multiplies
    for (int o = 0; o < 4; o++) begin
      run(3'(o), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      run(3'(o), 32'h8000_0000, 32'h8000_0000);
      run(3'(o), 32'h8000_0000, 32'h7FFF_FFFF);
      run(3'(o), 32'hFFFF_FFFE, 32'h0000_0003);
      run(3'(o), 32'h0000_0007, 32'hFFFF_FFFD);
      run(3'(o), 32'h0, 32'hDEAD_BEEF);
    end
    // R7, R8: all sign combinations
    for (int o = 4; o < 8; o++) begin
      run(3'(o), 32'd7, 32'd2);
      run(3'(o), -32'sd7, 32'd2);
      run(3'(o), 32'd7, -32'sd2);
      run(3'(o), -32'sd7, -32'sd2);
      run(3'(o), 32'd3, 32'd9);
      run(3'(o), 32'hFFFF_FFFF, 32'd1);
      // R9, R10: divide by zero
      run(3'(o), 32'h8765_4321, 32'h0);
      run(3'(o), 32'h0000_0005, 32'h0);
      // R11: overflow pair
      run(3'(o), 32'h8000_0000, 32'hFFFF_FFFF);
    end
    // R12: start during a run is ignored
    issue(3'd4, -32'sd100, 32'd7);
    repeat (5) @(negedge clk);
    op = 3'd5; a = 32'd1; b = 32'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_drain();
    repeat (40) @(negedge clk);
    check(busy == 1'b0, "R12 idle after ignored start", 32'(busy), 32'h0);
    check(result == ref_model(3'd4, -32'sd100, 32'd7), "R12 result held",
          result, ref_model(3'd4, -32'sd100, 32'd7));
    // back-to-back random
    for (int i = 0; i < 160; i++) begin
      logic [31:0] x, y;
      x = next_rand();
      y = next_rand();
      if (i % 4 == 1) y = y >> 20;
      if (i % 8 == 3) y = 32'h0;
      run(3'(i % 8), x, y);
    end
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule